// File: doc/BRIEF.md
# Multiplexed-Address Bit Memory with Open-Row Buffer

This block models a one-bit-wide memory whose cells form a square grid of rows and columns. The default geometry is 2048 rows by 2048 columns, which gives 4M cells. A full cell address has 22 bits. It arrives over a single set of 11 shared address pins in two steps: the row number first, then the column number.

When a row strobe arrives while the chip is selected, the whole row is copied from the cell array into a static row buffer, and the row stays open. Column strobes that follow pick single bits out of that buffer, so any number of column reads or writes can follow one row activation. A column write updates the buffer bit and the array bit on the same clock edge, so the value survives when the row is closed and later reopened. Driving the select pin high closes the open row.

The row and column widths are parameters, so a smaller grid can be built with the same split rules. Read data and the error flag are registered: both appear on the clock edge that follows the column strobe.

Top module: `dram_rowbuf`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `dout` is 0, `col_err` is 0 and no row is open. A column strobe issued right after reset therefore raises `col_err`.
- R2: With `sel_n`=0 and `row_stb`=1, the row named by `addr_bus` is opened. A column read (`sel_n`=0, `col_stb`=1, `row_stb`=0, `op_read`=1) puts that row's bit at column `addr_bus` on `dout` at the next rising edge, and `dout` holds that value until the next column read.
- R3: Any number of column reads may follow one row activation without another row strobe, and each returns the bit of the open row at its own column.
- R4: A column write (`op_read`=0) on an open row stores `din` in the buffer, so a read of that column before any new row strobe returns the written value.
- R5: A column write also stores `din` in the cell array on the same edge, so the value is returned after that row is closed or replaced and then opened again.
- R6: A column strobe with no open row is ignored: it writes nothing and leaves `dout` unchanged. `col_err` is 1 for exactly the one cycle after each such strobe.
- R7: A cycle with `sel_n`=1 closes the open row, so a later column strobe that is not preceded by a new row strobe raises `col_err`.
- R8: A row strobe while another row is open replaces the whole buffer with the new row, and later reads return the new row's bits.
- R9: When `row_stb` and `col_stb` are both high in one selected cycle, the row activation takes effect and the column operation is dropped: no write, `dout` unchanged, and `col_err` stays 0.
- R10: With `sel_n`=1, the strobes have no effect. No row is opened and no cell is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_bus | input | ADDR_W (11) | Shared address pins: row number with `row_stb`, column number with `col_stb` |
| row_stb | input | 1 | Row strobe; opens the addressed row |
| col_stb | input | 1 | Column strobe; reads or writes one bit of the open row |
| sel_n | input | 1 | Chip select, active low; high closes the row |
| op_read | input | 1 | 1 = column read, 0 = column write |
| din | input | 1 | Write data bit |
| dout | output | 1 | Registered read data bit |
| col_err | output | 1 | One-cycle flag for a column strobe with no open row |

## Verification
A row activation and a column operation can be requested in the same cycle, because both strobes share the same address pins. The bench provokes this by raising both strobes together, with a write pending and the address naming a row whose known bit would be overwritten if the column half were honoured. It then judges the outcome in four ways: `col_err` stays low, `dout` keeps its previous value, a read right after returns the new row's stored bit, and the cell that a wrongly accepted write would have hit still holds its old value.

// File: rtl/dram_rowbuf_pkg.sv
package dram_rowbuf_pkg;

    // Operation selected for one clock cycle
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_CLOSE  = 3'd1,
        OP_ACT    = 3'd2,
        OP_READ   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_ORPHAN = 3'd5
    } op_e;

    typedef struct packed {
        op_e  op;
        logic wbit;
    } cmd_t;

    // Priority: deselect, then row strobe, then column strobe
    function automatic op_e pick_op(input logic sel_n, input logic row_stb,
                                    input logic col_stb, input logic op_read,
                                    input logic row_open);
        op_e r;
        if (sel_n)              r = OP_CLOSE;
        else if (row_stb)       r = OP_ACT;
        else if (!col_stb)      r = OP_IDLE;
        else if (!row_open)     r = OP_ORPHAN;
        else if (op_read)       r = OP_READ;
        else                    r = OP_WRITE;
        return r;
    endfunction

    function automatic int unsigned max_bits(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
    import dram_rowbuf_pkg::*;
(
    input  logic sel_n,
    input  logic row_stb,
    input  logic col_stb,
    input  logic op_read,
    input  logic din,
    input  logic row_open,
    output cmd_t cmd
);
    always_comb begin
        cmd.op   = pick_op(sel_n, row_stb, col_stb, op_read, row_open);
        cmd.wbit = din;
    end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int unsigned ROW_BITS = 11,
    parameter int unsigned COL_BITS = 11
) (
    input  logic                  clk,
    input  logic [ROW_BITS-1:0]   rd_row,
    output logic [(1<<COL_BITS)-1:0] rd_data,
    input  logic                  we,
    input  logic [ROW_BITS-1:0]   wr_row,
    input  logic [COL_BITS-1:0]   wr_col,
    input  logic                  wr_bit
);
    localparam int unsigned ROWS = 1 << ROW_BITS;
    localparam int unsigned COLS = 1 << COL_BITS;

    logic [COLS-1:0] cells_q [ROWS];

    // Whole-row read for activation
    assign rd_data = cells_q[rd_row];

    // Single-bit write-through from the open row
    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[wr_row][wr_col] <= wr_bit;
        end
    end
endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer
    import dram_rowbuf_pkg::*;
#(
    parameter int unsigned ROW_BITS = 11,
    parameter int unsigned COL_BITS = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cmd_t                  cmd,
    input  logic [ROW_BITS-1:0]   row_addr,
    input  logic [COL_BITS-1:0]   col_addr,
    input  logic [(1<<COL_BITS)-1:0] fill_data,
    output logic                  row_open,
    output logic                  rd_bit,
    output logic                  arr_we,
    output logic [ROW_BITS-1:0]   arr_row,
    output logic [COL_BITS-1:0]   arr_col,
    output logic                  arr_bit
);
    localparam int unsigned COLS = 1 << COL_BITS;

    logic [COLS-1:0]     line_q;
    logic [ROW_BITS-1:0] open_row_q;
    logic                open_q;

    // Open-row bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            open_row_q <= '0;
        end else begin
            unique case (cmd.op)
                OP_CLOSE: open_q <= 1'b0;
                OP_ACT: begin
                    open_q     <= 1'b1;
                    open_row_q <= row_addr;
                end
                default: ;
            endcase
        end
    end

    // Buffer contents: full copy on activation, single bit on write
    always_ff @(posedge clk) begin
        if (cmd.op == OP_ACT) begin
            line_q <= fill_data;
        end else if (cmd.op == OP_WRITE) begin
            line_q[col_addr] <= cmd.wbit;
        end
    end

    assign row_open = open_q;
    assign rd_bit   = line_q[col_addr];
    assign arr_we   = (cmd.op == OP_WRITE);
    assign arr_row  = open_row_q;
    assign arr_col  = col_addr;
    assign arr_bit  = cmd.wbit;
endmodule

// File: rtl/dram_out_stage.sv
module dram_out_stage
    import dram_rowbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic rd_bit,
    output logic dout,
    output logic col_err
);
    logic dout_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (cmd.op == OP_READ) begin
                dout_q <= rd_bit;
            end
            err_q <= (cmd.op == OP_ORPHAN);
        end
    end

    assign dout    = dout_q;
    assign col_err = err_q;
endmodule

// File: rtl/dram_rowbuf.sv
module dram_rowbuf
    import dram_rowbuf_pkg::*;
#(
    parameter int unsigned ROW_BITS = 11,
    parameter int unsigned COL_BITS = 11,
    localparam int unsigned ADDR_W  = max_bits(ROW_BITS, COL_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic              row_stb,
    input  logic              col_stb,
    input  logic              sel_n,
    input  logic              op_read,
    input  logic              din,
    output logic              dout,
    output logic              col_err
);
    localparam int unsigned COLS = 1 << COL_BITS;

    cmd_t                cmd;
    logic                row_open;
    logic                rd_bit;
    logic [COLS-1:0]     fill_data;
    logic                arr_we;
    logic [ROW_BITS-1:0] arr_row;
    logic [COL_BITS-1:0] arr_col;
    logic                arr_bit;
    logic [ROW_BITS-1:0] row_addr;
    logic [COL_BITS-1:0] col_addr;

    // Both halves of the address share the same pins
    assign row_addr = addr_bus[ROW_BITS-1:0];
    assign col_addr = addr_bus[COL_BITS-1:0];

    dram_cmd_decode u_dec (
        .sel_n    (sel_n),
        .row_stb  (row_stb),
        .col_stb  (col_stb),
        .op_read  (op_read),
        .din      (din),
        .row_open (row_open),
        .cmd      (cmd)
    );

    dram_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_arr (
        .clk     (clk),
        .rd_row  (row_addr),
        .rd_data (fill_data),
        .we      (arr_we),
        .wr_row  (arr_row),
        .wr_col  (arr_col),
        .wr_bit  (arr_bit)
    );

    dram_row_buffer #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .fill_data (fill_data),
        .row_open  (row_open),
        .rd_bit    (rd_bit),
        .arr_we    (arr_we),
        .arr_row   (arr_row),
        .arr_col   (arr_col),
        .arr_bit   (arr_bit)
    );

    dram_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .rd_bit  (rd_bit),
        .dout    (dout),
        .col_err (col_err)
    );
endmodule

// File: rtl/dram_rowbuf_chk.sv
module dram_rowbuf_chk (
    input logic clk,
    input logic rst,
    input logic row_stb,
    input logic col_stb,
    input logic sel_n,
    input logic op_read,
    input logic dout,
    input logic col_err,
    input logic row_open
);
    // R2: a selected row strobe leaves a row open
    assert_row_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && row_stb) |=> row_open);

    // R2: dout only moves after an accepted column read
    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(!sel_n && col_stb && !row_stb && op_read && row_open) |=> $stable(dout));

    // R6: orphan column strobe flags an error next cycle
    assert_orphan_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && col_stb && !row_stb && !row_open) |=> col_err);

    // R6: error flag never appears without a closed-row column strobe
    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (rst)
        col_err |-> $past(!sel_n && col_stb && !row_stb && !row_open));

    // R7 and R10: deselect closes the row
    assert_desel_closes_R7: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !row_open);

    // R9: both strobes together never raise the error flag
    assert_dual_no_err_R9: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && row_stb && col_stb) |=> !col_err);
endmodule

bind dram_rowbuf dram_rowbuf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .row_stb  (row_stb),
    .col_stb  (col_stb),
    .sel_n    (sel_n),
    .op_read  (op_read),
    .dout     (dout),
    .col_err  (col_err),
    .row_open (row_open)
);

// File: tb/sim_dram_rowbuf.sv
`timescale 1ns/1ps
module sim_dram_rowbuf;
    localparam int ROW_BITS = 11;
    localparam int COL_BITS = 11;
    localparam int ADDR_W   = 11;
    localparam int LAST     = (1 << COL_BITS) - 1;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr_bus;
    logic              row_stb, col_stb, sel_n, op_read, din;
    logic              dout, col_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    dram_rowbuf #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u0 (
        .clk(clk), .rst(rst), .addr_bus(addr_bus), .row_stb(row_stb),
        .col_stb(col_stb), .sel_n(sel_n), .op_read(op_read), .din(din),
        .dout(dout), .col_err(col_err)
    );

    task automatic check(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // One clock cycle with the given pins; returns 1 ns after the edge
    task automatic cyc(input logic s_n, input logic rs, input logic cs,
                       input logic rd, input int a, input logic d);
        sel_n = s_n; row_stb = rs; col_stb = cs; op_read = rd;
        addr_bus = ADDR_W'(a); din = d;
        @(posedge clk); #1;
    endtask

    task automatic idle();                 cyc(0, 0, 0, 1, 0, 0); endtask
    task automatic open_row(input int r);  cyc(0, 1, 0, 1, r, 0); endtask
    task automatic wr(input int c, input logic d); cyc(0, 0, 1, 0, c, d); endtask
    task automatic rd(input int c);        cyc(0, 0, 1, 1, c, 0); endtask
    task automatic deselect();             cyc(1, 0, 0, 1, 0, 0); endtask

    task automatic t_reset();
        check("R1", "dout after reset", dout, 1'b0);
        check("R1", "col_err after reset", col_err, 1'b0);
        rd(3);
        check("R1", "column strobe right after reset flags", col_err, 1'b1);
        idle();
        check("R6", "flag lasts one cycle", col_err, 1'b0);
    endtask

    task automatic t_buffer_rw();
        open_row(5);
        wr(0, 1); wr(1, 0); wr(LAST, 1); wr(3, 1);
        rd(0);    check("R4", "read back col 0", dout, 1'b1);
        rd(1);    check("R3", "second read col 1", dout, 1'b0);
        rd(LAST); check("R3", "third read last col", dout, 1'b1);
        idle(); idle();
        check("R2", "dout holds across idle", dout, 1'b1);
        wr(1, 1);
        check("R2", "write leaves dout", dout, 1'b1);
        wr(1, 0);
        rd(1);    check("R4", "rewrite col 1", dout, 1'b0);
        rd(3);    check("R3", "fourth read col 3", dout, 1'b1);
    endtask

    task automatic t_replace_persist();
        open_row(LAST);
        wr(0, 0); wr(5, 1);
        open_row(5);
        rd(0);    check("R8", "new row replaces buffer", dout, 1'b1);
        open_row(LAST);
        rd(5);    check("R5", "row LAST col 5 kept in array", dout, 1'b1);
        rd(0);    check("R5", "row LAST col 0 kept in array", dout, 1'b0);
        deselect();
        open_row(5);
        rd(LAST); check("R5", "row 5 value after close/reopen", dout, 1'b1);
    endtask

    task automatic t_close_orphan();
        open_row(5);
        rd(0);    check("R2", "setup dout=1", dout, 1'b1);
        deselect();
        rd(1);
        check("R7", "column after close flags", col_err, 1'b1);
        check("R6", "orphan read leaves dout", dout, 1'b1);
        wr(1, 1);
        check("R6", "orphan write also flags", col_err, 1'b1);
        idle();
        check("R6", "flag drops", col_err, 1'b0);
        open_row(5);
        rd(1);    check("R6", "orphan write stored nothing", dout, 1'b0);
    endtask

    task automatic t_dual_strobe();
        open_row(1);
        wr(1, 0);
        rd(1);    check("R4", "row 1 col 1 = 0", dout, 1'b0);
        open_row(5);
        rd(0);    check("R2", "dout=1 before dual", dout, 1'b1);
        cyc(0, 1, 1, 0, 1, 1);   // both strobes, write of 1 to address 1
        check("R9", "no flag on dual strobe", col_err, 1'b0);
        check("R9", "dout unchanged on dual strobe", dout, 1'b1);
        rd(1);    check("R9", "row 1 opened and col 1 not written", dout, 1'b0);
        open_row(5);
        rd(1);    check("R9", "row 5 col 1 untouched", dout, 1'b0);
    endtask

    task automatic t_deselected_strobes();
        open_row(1);
        cyc(1, 1, 0, 1, 5, 0);   // row strobe while deselected
        rd(0);
        check("R10", "deselected row strobe opens nothing", col_err, 1'b1);
        open_row(1);
        cyc(1, 0, 1, 0, 1, 1);   // write while deselected
        open_row(1);
        rd(1);    check("R10", "deselected write stored nothing", dout, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sel_n = 1'b1; row_stb = 1'b0; col_stb = 1'b0; op_read = 1'b1;
        addr_bus = '0; din = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "dout during reset", dout, 1'b0);
        rst = 1'b0;
        idle();
        t_reset();
        t_buffer_rw();
        t_replace_persist();
        t_close_orphan();
        t_dual_strobe();
        t_deselected_strobes();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule